// File: doc/BRIEF.md
# Processor Supervisor Reset Sequencer

This block collects every condition that should hold a processor in reset and turns them into one reset of guaranteed minimum length. There are four sources. The first is a low supply during power-up or later; two external comparators each supply a flag, and a tolerance-select bit chooses which flag applies. The second is a manual push-button. The third is a watchdog-timeout pulse. The fourth is the block's own power-on state, since it comes out of reset with the processor reset asserted. The block drives the result on two pins of opposite polarity.

All timing is counted on a 1 ms tick enable that runs beside the free-running clock. The push-button is filtered, so a glitch shorter than one tick has no effect and a firm press always gets through. Once every cause has gone away, the reset is held for a configurable number of ticks, 610 by default. Any cause that arrives during this hold starts the count again from zero.

Top module: `supv_reset_seq`

## Requirements
- R1: While `rst_n` is low and for the whole power-up hold after it, `rst_hi_o` is 1 and `rst_lo_n_o` is 0.
- R2: Once the selected undervoltage flag clears and no other cause is present, reset releases after HOLD_MS ticks, and never before HOLD_MS-1 tick periods have elapsed.
- R3: `tol_sel_i` = 0 selects `uv_5pct_i` and `tol_sel_i` = 1 selects `uv_10pct_i`. The flag that is not selected has no effect on the reset outputs.
- R4: A selected undervoltage flag at 1 asserts reset within 4 clock cycles and keeps it asserted for as long as the flag stays at 1.
- R5: A low pulse on `pb_n_i` that spans fewer than PB_DEB_MS ticks is ignored, so no reset follows. With the default of 2, any pulse shorter than 1 ms is ignored.
- R6: `pb_n_i` held low for PB_DEB_MS ticks or longer asserts reset. The delay from the press to reset is at least one tick period and at most 20 tick periods.
- R7: A 1 on `wdt_expire_i` for one clock cycle asserts reset within 4 clock cycles.
- R8: A cause that arrives while reset is held restarts the hold, so the release comes HOLD_MS ticks after the last cause.
- R9: `rst_lo_n_o` is always the complement of `rst_hi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_ms_i | input | 1 | One-cycle enable, once per millisecond |
| uv_5pct_i | input | 1 | Undervoltage flag for the tight threshold (asynchronous) |
| uv_10pct_i | input | 1 | Undervoltage flag for the loose threshold (asynchronous) |
| tol_sel_i | input | 1 | Threshold select: 0 = tight, 1 = loose |
| pb_n_i | input | 1 | Push-button, active low (asynchronous) |
| wdt_expire_i | input | 1 | Watchdog timeout pulse |
| rst_hi_o | output | 1 | Processor reset, active high |
| rst_lo_n_o | output | 1 | Processor reset, active low |

## Verification
A level cause reaches the outputs four clock edges after it changes: two synchronizer flops, the hold flag and the output register. The bench therefore samples on falling edges, at least five cycles after it drives a cause. Release depends on the tick, so its cycle is not fixed. The bench counts the cycles from the cause dropping to the release and accepts any count between (HOLD_MS-1) tick periods and HOLD_MS tick periods plus the pipeline delay. The push-button delay is measured the same way, against a window of one to twenty tick periods.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // bit positions of the synchronized input bundle
  localparam int unsigned SB_WDT  = 0;
  localparam int unsigned SB_PB   = 1;
  localparam int unsigned SB_UV5  = 2;
  localparam int unsigned SB_UV10 = 3;
  localparam int unsigned SB_TOL  = 4;
  localparam int unsigned SYNC_W  = 5;

  // values the synchronizers take during block reset: supply assumed bad,
  // button released, no timeout, tight threshold
  localparam logic [SYNC_W-1:0] SYNC_RST = 5'b01110;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned           W       = 1,
  parameter int unsigned           STAGES  = 2,
  parameter logic [W-1:0]          RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/supv_pb_filter.sv
module supv_pb_filter #(
  parameter int unsigned DEB_MS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pb_n_s_i,
  output logic press_o
);
  localparam int unsigned CW = supv_pkg::cnt_width(DEB_MS);
  localparam logic [CW-1:0] LAST = CW'(DEB_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          press_q, press_d;

  always_comb begin
    cnt_d   = cnt_q;
    press_d = press_q;
    if (pb_n_s_i) begin
      cnt_d   = '0;
      press_d = 1'b0;
    end else if (tick_i && !press_q) begin
      if (cnt_q == LAST) press_d = 1'b1;
      else               cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      press_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      press_q <= press_d;
    end
  end

  assign press_o = press_q;
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
  parameter int unsigned HOLD_MS = 610
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cause_i,
  output logic active_o
);
  localparam int unsigned HW = supv_pkg::cnt_width(HOLD_MS);
  localparam logic [HW-1:0] LAST = HW'(HOLD_MS - 1);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (cause_i) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q && tick_i) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
  parameter int unsigned HOLD_MS   = 610,
  parameter int unsigned PB_DEB_MS = 2,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms_i,
  input  logic uv_5pct_i,
  input  logic uv_10pct_i,
  input  logic tol_sel_i,
  input  logic pb_n_i,
  input  logic wdt_expire_i,
  output logic rst_hi_o,
  output logic rst_lo_n_o
);
  import supv_pkg::*;

  logic [SYNC_W-1:0] raw, syn;
  logic uv_sel, pb_press, cause, active;
  logic out_hi_q, out_lo_q;

  always_comb begin
    raw          = '0;
    raw[SB_WDT]  = wdt_expire_i;
    raw[SB_PB]   = pb_n_i;
    raw[SB_UV5]  = uv_5pct_i;
    raw[SB_UV10] = uv_10pct_i;
    raw[SB_TOL]  = tol_sel_i;
  end

  supv_sync #(.W(SYNC_W), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  supv_pb_filter #(.DEB_MS(PB_DEB_MS)) u_pb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_ms_i),
    .pb_n_s_i(syn[SB_PB]), .press_o(pb_press)
  );

  assign uv_sel = syn[SB_TOL] ? syn[SB_UV10] : syn[SB_UV5];
  assign cause  = uv_sel | pb_press | syn[SB_WDT];

  supv_hold_timer #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_ms_i),
    .cause_i(cause), .active_o(active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hi_q <= 1'b1;
      out_lo_q <= 1'b0;
    end else begin
      out_hi_q <= active;
      out_lo_q <= ~active;
    end
  end

  assign rst_hi_o   = out_hi_q;
  assign rst_lo_n_o = out_lo_q;
endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_ms_i,
  input logic uv_sel,
  input logic pb_press,
  input logic cause,
  input logic active,
  input logic rst_hi_o,
  input logic rst_lo_n_o
);
  // R9: the two pins never agree
  p_compl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hi_o != rst_lo_n_o);

  // R4: an undervoltage cause forces the hold flag on the next edge
  p_uv_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uv_sel |=> active);

  // R1: the output register follows the hold flag one cycle later
  p_out_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> rst_hi_o);

  // R2: release happens only on a tick and only with no cause present
  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(tick_ms_i) && !$past(cause)));

  // R5: the filtered press can only rise on a tick
  p_pb_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pb_press) |-> $past(tick_ms_i));

  // R8: with no tick the hold flag cannot drop
  p_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick_ms_i) |=> active);
endmodule

bind supv_reset_seq supv_reset_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms_i(tick_ms_i),
  .uv_sel(uv_sel), .pb_press(pb_press), .cause(cause), .active(active),
  .rst_hi_o(rst_hi_o), .rst_lo_n_o(rst_lo_n_o)
);

// File: tb/tb_supv_reset_seq.sv
module tb_supv_reset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_CYC   = 4;
  localparam int HOLD_MS    = 610;
  localparam int PB_DEB_MS  = 2;
  localparam int REL_LO     = (HOLD_MS - 1) * TICK_CYC;
  localparam int REL_HI     = HOLD_MS * TICK_CYC + 8;

  // vector: {tol, uv5, uv10, expect_reset}
  localparam logic [3:0] VEC [8] = '{
    4'b0010, 4'b1100, 4'b0000, 4'b1000,
    4'b0101, 4'b1011, 4'b0111, 4'b1111
  };

  logic clk = 1'b0;
  logic rst_n, tick, uv5, uv10, tol, pb_n, wdt;
  logic rst_hi, rst_lo_n;
  int   checks = 0, fails = 0, tick_cnt = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == TICK_CYC-1) ? 0 : tick_cnt + 1;
    tick     <= (tick_cnt == TICK_CYC-1);
  end

  supv_reset_seq #(.HOLD_MS(HOLD_MS), .PB_DEB_MS(PB_DEB_MS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms_i(tick),
    .uv_5pct_i(uv5), .uv_10pct_i(uv10), .tol_sel_i(tol),
    .pb_n_i(pb_n), .wdt_expire_i(wdt),
    .rst_hi_o(rst_hi), .rst_lo_n_o(rst_lo_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic exp);
    check(rst_hi === exp, req, int'(rst_hi), int'(exp));
    check(rst_lo_n === ~exp, {req, "/R9"}, int'(rst_lo_n), int'(~exp));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts cycles until reset releases, bounded
  task automatic wait_release(output int n);
    n = 0;
    while (rst_hi === 1'b1 && n < REL_HI + 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; uv5 = 1'b1; uv10 = 1'b1; tol = 1'b0; pb_n = 1'b1; wdt = 1'b0;
    tick = 1'b0;
    cyc(5);
    chk_out("R1 in reset", 1'b1);
    rst_n = 1'b1;
    // R4: power-up with tight flag still set holds reset
    cyc(100);
    chk_out("R4 uv held", 1'b1);
    uv5 = 1'b0; uv10 = 1'b0;
    cyc(20);
    chk_out("R1 power-up hold", 1'b1);
    wait_release(n);
    n += 20;
    check(n >= REL_LO && n <= REL_HI, "R2 release time", n, HOLD_MS * TICK_CYC);
    cyc(3);
    chk_out("R2 released", 1'b0);

    // R3/R4 table walk
    foreach (VEC[i]) begin
      tol = VEC[i][3]; uv5 = VEC[i][2]; uv10 = VEC[i][1];
      cyc(6);
      chk_out(VEC[i][0] ? "R4 selected flag" : "R3 unselected flag", VEC[i][0]);
      uv5 = 1'b0; uv10 = 1'b0;
      if (VEC[i][0]) begin
        wait_release(n);
        check(n >= REL_LO && n <= REL_HI, "R2 release after uv", n, HOLD_MS * TICK_CYC);
        cyc(2);
      end
    end
    tol = 1'b0;

    // R5: short push-button pulses rejected
    for (int k = 0; k < 4; k++) begin
      pb_n = 1'b0; cyc(1 + (k % 3)); pb_n = 1'b1;
      cyc(3 * TICK_CYC + 5);
      chk_out("R5 short press ignored", 1'b0);
    end

    // R6: held press resets within window
    pb_n = 1'b0;
    n = 0;
    while (rst_hi !== 1'b1 && n < 40 * TICK_CYC) begin @(negedge clk); n++; end
    check(n >= TICK_CYC && n <= 20 * TICK_CYC, "R6 press delay", n, (PB_DEB_MS + 1) * TICK_CYC);
    cyc(30 * TICK_CYC);
    chk_out("R6 held press keeps reset", 1'b1);
    pb_n = 1'b1;
    wait_release(n);
    check(n >= REL_LO && n <= REL_HI, "R2 release after press", n, HOLD_MS * TICK_CYC);
    cyc(2);

    // R7: watchdog pulse
    wdt = 1'b1; cyc(1); wdt = 1'b0;
    cyc(4);
    chk_out("R7 wdt reset", 1'b1);
    wait_release(n);
    check(n >= REL_LO - 5 && n <= REL_HI, "R7 wdt hold", n, HOLD_MS * TICK_CYC);
    cyc(2);

    // R8: retrigger during hold restarts the count
    wdt = 1'b1; cyc(1); wdt = 1'b0;
    cyc(HOLD_MS * TICK_CYC / 2);
    chk_out("R8 mid hold", 1'b1);
    wdt = 1'b1; cyc(1); wdt = 1'b0;
    cyc(HOLD_MS * TICK_CYC / 2 + 40);
    chk_out("R8 retriggered still held", 1'b1);
    wait_release(n);
    n += HOLD_MS * TICK_CYC / 2 + 41;
    check(n >= REL_LO && n <= REL_HI, "R8 release after last cause", n, HOLD_MS * TICK_CYC);

    // R1: block reset reasserts outputs at once
    cyc(3);
    rst_n = 1'b0; cyc(1);
    chk_out("R1 async reset", 1'b1);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule